// File: doc/BRIEF.md
# Serial Configuration Write Slave

This block receives configuration writes over a three-wire serial link: a serial clock, an active-low load strobe and a data line. All three pins are asynchronous to the block's system clock. They are brought in through two-flop synchronisers, and their edges are detected in the system domain. The system clock must run at least four times faster than the serial clock. Every frame opens with an 8-bit address. Every field is sent most-significant bit first.

Most addresses select a single 24-bit control register. The block holds eight such registers, scattered over the address space. A control write is captured during the strobe's low period, but it only reaches the outputs when the strobe rises. Three addresses start a counted burst instead. The burst carries a 24-bit word count, followed by 32-bit words that fill a bank in ascending order from index 0. The three banks are a 17-entry system bank and two 8-entry mode banks. Bit 0 of one control register selects which mode bank is presented to the core.

Top module: `ser_write_if`

## Requirements
- R1: After reset, all control registers, all bank entries, the mode select and the error flag read zero.
- R2: Data is sampled on each serial clock rising edge while the load strobe is low. A control write is 8 address bits, then 24 data bits. Implemented addresses and their slots are: 0x00→0, 0x03→1, 0x0A→2, 0x21→3, 0x40→4, 0x7F→5, 0xA5→6, 0xD6→7. Slot k appears on ctrl_regs_o[24k+23:24k].
- R3: A control write reaches ctrl_regs_o only at the rising edge of the load strobe, and only after all 32 bits have arrived. A strobe that rises earlier discards the frame. If the last serial clock rise and the strobe rise are seen in the same system cycle, the last bit is kept and the write commits.
- R4: Bits after the first 32 in one low period are ignored, so only one control address is written per low period. A following frame is handled normally.
- R5: A write to an address with no slot changes no output.
- R6: mode_sel_o is bit 0 of the register at address 0x0A. mode_bank_o shows mode bank A when this bit is 0 and mode bank B when it is 1. Entry k sits at bits [32k+31:32k].
- R7: Address 0x14 is followed by a 24-bit count, then 32-bit words. Word j goes to system entry j, and each entry becomes visible on sys_regs_o[32j+31:32j] once its 32nd bit has arrived.
- R8: A count of zero means the whole bank. A count larger than the bank is clamped to the bank size, and the surplus words are ignored. A smaller count writes only that many entries and leaves the rest unchanged.
- R9: A burst continues across strobe high periods until its words are complete. Serial clock edges seen while the strobe is high are not counted.
- R10: Addresses 0x15 and 0x16 burst in the same way into the 8-entry mode banks A and B.
- R11: proto_err_o pulses for one system cycle when the strobe falls before any serial clock rise has occurred since its last rise, outside a burst. The frame is still accepted. A high period that contains a serial clock rise raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_load_n_i | input | 1 | Active-low load strobe, asynchronous |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ctrl_regs_o | output | 192 | Eight 24-bit control registers, slot k at [24k+23:24k] |
| mode_sel_o | output | 1 | Active mode bank select |
| sys_regs_o | output | 544 | Seventeen 32-bit system entries |
| mode_bank_o | output | 256 | Eight 32-bit entries of the selected mode bank |
| proto_err_o | output | 1 | One-cycle pulse on a too-short strobe high period |

## Verification
Two events can land in the same system cycle: the final data bit of a control frame and the strobe rise that commits it. The bench drives the last serial clock rise and the strobe rise at the same instant, so both edges reach the synchronised domain together. It then checks that the slot holds the full word, including that last bit. A second overlap is a burst word completing while the strobe toggles mid-burst. The bench judges this by checking that the bank entries on either side of the split hold the intended words.

// File: rtl/ser_cfg_pkg.sv
`timescale 1ns/1ps
package ser_cfg_pkg;
    localparam int ADDR_W  = 8;
    localparam int CDATA_W = 24;
    localparam int CNT_W   = 24;
    localparam int WORD_W  = 32;
    localparam int SYS_N   = 17;
    localparam int MODE_N  = 8;
    localparam int CTRL_N  = 8;
    localparam int IDX_W   = $clog2(SYS_N + 1);
    localparam int MIDX_W  = $clog2(MODE_N);
    localparam int SLOT_W  = $clog2(CTRL_N);
    localparam int BIT_W   = $clog2(WORD_W);
    localparam int MODE_SLOT = 2;

    localparam int PIN_SCK = 0;
    localparam int PIN_LD  = 1;
    localparam int PIN_DAT = 2;
    localparam int PIN_N   = 3;
    localparam logic [PIN_N-1:0] PIN_RST = 3'b010;

    localparam logic [ADDR_W-1:0] ADR_SYS    = 8'h14;
    localparam logic [ADDR_W-1:0] ADR_MODE_A = 8'h15;
    localparam logic [ADDR_W-1:0] ADR_MODE_B = 8'h16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_CDATA, ST_CDONE, ST_COUNT, ST_WORD, ST_SKIP
    } frame_st_e;

    typedef enum logic [1:0] { BK_SYS, BK_MODE_A, BK_MODE_B } bank_e;

    typedef struct packed {
        logic               valid;
        logic [SLOT_W-1:0]  slot;
        logic [CDATA_W-1:0] data;
    } ctrl_wr_t;

    typedef struct packed {
        logic              valid;
        bank_e             bank;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } bank_wr_t;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } slot_t;

    // Sparse control map: slot order is the order of this list.
    function automatic logic [ADDR_W-1:0] slot_addr(int unsigned s);
        case (s)
            0:       return 8'h00;
            1:       return 8'h03;
            2:       return 8'h0A;
            3:       return 8'h21;
            4:       return 8'h40;
            5:       return 8'h7F;
            6:       return 8'hA5;
            default: return 8'hD6;
        endcase
    endfunction

    function automatic slot_t find_slot(logic [ADDR_W-1:0] a);
        slot_t r;
        r = '0;
        for (int i = 0; i < CTRL_N; i++) begin
            if (slot_addr(i) == a) begin
                r.hit  = 1'b1;
                r.slot = SLOT_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic is_burst(logic [ADDR_W-1:0] a);
        return (a == ADR_SYS) || (a == ADR_MODE_A) || (a == ADR_MODE_B);
    endfunction

    function automatic bank_e addr_bank(logic [ADDR_W-1:0] a);
        if (a == ADR_MODE_A) return BK_MODE_A;
        if (a == ADR_MODE_B) return BK_MODE_B;
        return BK_SYS;
    endfunction

    function automatic logic [IDX_W-1:0] bank_size(bank_e b);
        return (b == BK_SYS) ? IDX_W'(SYS_N) : IDX_W'(MODE_N);
    endfunction

    function automatic logic [IDX_W-1:0] burst_len(bank_e b, logic [CNT_W-1:0] n);
        logic [IDX_W-1:0] sz;
        sz = bank_size(b);
        if (n == '0 || n > {{(CNT_W-IDX_W){1'b0}}, sz}) return sz;
        return n[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/ser_sync.sv
`timescale 1ns/1ps
module ser_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cur_o
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    assign cur_o = sync_q;
endmodule

// File: rtl/ser_frame.sv
`timescale 1ns/1ps
module ser_frame
    import ser_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sck_i,
    input  logic     ld_i,
    input  logic     dat_i,
    output ctrl_wr_t ctrl_wr_o,
    output bank_wr_t bank_wr_o,
    output logic     err_o
);
    frame_st_e          st_q, st_n;
    logic [WORD_W-1:0]  sh_q, sh_n;
    logic [BIT_W-1:0]   cnt_q, cnt_n;
    bank_e              bank_q, bank_n;
    logic [IDX_W-1:0]   len_q, len_n, widx_q, widx_n;
    slot_t              cslot_q, cslot_n;
    logic [CDATA_W-1:0] cdata_q, cdata_n;
    logic               gap_q, gap_n;
    logic               sck_prev_q, ld_prev_q;
    logic               sck_rise, ld_rise, ld_fall, in_burst, take_bit;
    ctrl_wr_t           cwr_n;
    bank_wr_t           bwr_n;
    logic               err_n;

    assign sck_rise = sck_i & ~sck_prev_q;
    assign ld_rise  = ld_i & ~ld_prev_q;
    assign ld_fall  = ~ld_i & ld_prev_q;
    assign in_burst = (st_q == ST_COUNT) || (st_q == ST_WORD);

    always_comb begin
        st_n = st_q; sh_n = sh_q; cnt_n = cnt_q; bank_n = bank_q;
        len_n = len_q; widx_n = widx_q; cslot_n = cslot_q; cdata_n = cdata_q;
        gap_n = gap_q; cwr_n = '0; bwr_n = '0; err_n = 1'b0;

        if (ld_fall) begin
            if (!gap_q && !in_burst) err_n = 1'b1;
            if (st_q == ST_IDLE) begin
                st_n  = ST_ADDR;
                cnt_n = '0;
            end
        end
        if (sck_rise && ld_i && ld_prev_q) gap_n = 1'b1;

        // Bit sampled with the strobe level seen before this cycle's edge.
        take_bit = sck_rise && !ld_prev_q &&
                   (st_n == ST_ADDR || st_n == ST_CDATA ||
                    st_n == ST_COUNT || st_n == ST_WORD);
        if (take_bit) begin
            sh_n = {sh_q[WORD_W-2:0], dat_i};
            unique case (st_n)
                ST_ADDR: begin
                    if (cnt_n == BIT_W'(ADDR_W - 1)) begin
                        cnt_n = '0;
                        if (is_burst(sh_n[ADDR_W-1:0])) begin
                            bank_n = addr_bank(sh_n[ADDR_W-1:0]);
                            st_n   = ST_COUNT;
                        end else begin
                            cslot_n = find_slot(sh_n[ADDR_W-1:0]);
                            st_n    = ST_CDATA;
                        end
                    end else cnt_n = cnt_n + 1'b1;
                end
                ST_CDATA: begin
                    if (cnt_n == BIT_W'(CDATA_W - 1)) begin
                        cnt_n   = '0;
                        cdata_n = sh_n[CDATA_W-1:0];
                        st_n    = ST_CDONE;
                    end else cnt_n = cnt_n + 1'b1;
                end
                ST_COUNT: begin
                    if (cnt_n == BIT_W'(CNT_W - 1)) begin
                        cnt_n  = '0;
                        len_n  = burst_len(bank_n, sh_n[CNT_W-1:0]);
                        widx_n = '0;
                        st_n   = ST_WORD;
                    end else cnt_n = cnt_n + 1'b1;
                end
                default: begin
                    if (cnt_n == BIT_W'(WORD_W - 1)) begin
                        cnt_n      = '0;
                        bwr_n.valid = 1'b1;
                        bwr_n.bank  = bank_n;
                        bwr_n.idx   = widx_n;
                        bwr_n.data  = sh_n;
                        if (widx_n + IDX_W'(1) == len_n) st_n = ST_SKIP;
                        else widx_n = widx_n + IDX_W'(1);
                    end else cnt_n = cnt_n + 1'b1;
                end
            endcase
        end

        if (ld_rise) begin
            gap_n = 1'b0;
            unique case (st_n)
                ST_ADDR, ST_CDATA, ST_SKIP: st_n = ST_IDLE;
                ST_CDONE: begin
                    cwr_n.valid = cslot_n.hit;
                    cwr_n.slot  = cslot_n.slot;
                    cwr_n.data  = cdata_n;
                    st_n        = ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE; sh_q <= '0; cnt_q <= '0; bank_q <= BK_SYS;
            len_q <= '0; widx_q <= '0; cslot_q <= '0; cdata_q <= '0;
            gap_q <= 1'b1; sck_prev_q <= 1'b0; ld_prev_q <= 1'b1;
            ctrl_wr_o <= '0; bank_wr_o <= '0; err_o <= 1'b0;
        end else begin
            st_q <= st_n; sh_q <= sh_n; cnt_q <= cnt_n; bank_q <= bank_n;
            len_q <= len_n; widx_q <= widx_n; cslot_q <= cslot_n; cdata_q <= cdata_n;
            gap_q <= gap_n; sck_prev_q <= sck_i; ld_prev_q <= ld_i;
            ctrl_wr_o <= cwr_n; bank_wr_o <= bwr_n; err_o <= err_n;
        end
    end
endmodule

// File: rtl/ser_regs.sv
`timescale 1ns/1ps
module ser_regs
    import ser_cfg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  ctrl_wr_t                  ctrl_wr_i,
    input  bank_wr_t                  bank_wr_i,
    output logic [CTRL_N*CDATA_W-1:0] ctrl_o,
    output logic                      mode_sel_o,
    output logic [SYS_N*WORD_W-1:0]   sys_o,
    output logic [MODE_N*WORD_W-1:0]  act_o
);
    logic [CDATA_W-1:0] ctrl_q [CTRL_N];
    logic [WORD_W-1:0]  sys_q  [SYS_N];
    logic [WORD_W-1:0]  ma_q   [MODE_N];
    logic [WORD_W-1:0]  mb_q   [MODE_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CTRL_N; i++) ctrl_q[i] <= '0;
            for (int i = 0; i < SYS_N; i++)  sys_q[i]  <= '0;
            for (int i = 0; i < MODE_N; i++) begin
                ma_q[i] <= '0;
                mb_q[i] <= '0;
            end
        end else begin
            if (ctrl_wr_i.valid) ctrl_q[ctrl_wr_i.slot] <= ctrl_wr_i.data;
            if (bank_wr_i.valid) begin
                unique case (bank_wr_i.bank)
                    BK_MODE_A: ma_q[bank_wr_i.idx[MIDX_W-1:0]] <= bank_wr_i.data;
                    BK_MODE_B: mb_q[bank_wr_i.idx[MIDX_W-1:0]] <= bank_wr_i.data;
                    default:   sys_q[bank_wr_i.idx] <= bank_wr_i.data;
                endcase
            end
        end
    end

    assign mode_sel_o = ctrl_q[MODE_SLOT][0];

    for (genvar g = 0; g < CTRL_N; g++) begin : g_ctrl
        assign ctrl_o[g*CDATA_W +: CDATA_W] = ctrl_q[g];
    end
    for (genvar g = 0; g < SYS_N; g++) begin : g_sys
        assign sys_o[g*WORD_W +: WORD_W] = sys_q[g];
    end
    for (genvar g = 0; g < MODE_N; g++) begin : g_mode
        assign act_o[g*WORD_W +: WORD_W] = mode_sel_o ? mb_q[g] : ma_q[g];
    end
endmodule

// File: rtl/ser_write_if.sv
`timescale 1ns/1ps
module ser_write_if
    import ser_cfg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ser_clk_i,
    input  logic                      ser_load_n_i,
    input  logic                      ser_data_i,
    output logic [CTRL_N*CDATA_W-1:0] ctrl_regs_o,
    output logic                      mode_sel_o,
    output logic [SYS_N*WORD_W-1:0]   sys_regs_o,
    output logic [MODE_N*WORD_W-1:0]  mode_bank_o,
    output logic                      proto_err_o
);
    logic [PIN_N-1:0] pins, s_cur;
    ctrl_wr_t         ctrl_wr;
    bank_wr_t         bank_wr;

    assign pins = {ser_data_i, ser_load_n_i, ser_clk_i};

    ser_sync #(.W(PIN_N), .RST_VAL(PIN_RST)) u_sync (
        .clk(clk), .rst(rst), .pin_i(pins), .cur_o(s_cur)
    );

    ser_frame u_frame (
        .clk(clk), .rst(rst),
        .sck_i(s_cur[PIN_SCK]), .ld_i(s_cur[PIN_LD]), .dat_i(s_cur[PIN_DAT]),
        .ctrl_wr_o(ctrl_wr), .bank_wr_o(bank_wr), .err_o(proto_err_o)
    );

    ser_regs u_regs (
        .clk(clk), .rst(rst), .ctrl_wr_i(ctrl_wr), .bank_wr_i(bank_wr),
        .ctrl_o(ctrl_regs_o), .mode_sel_o(mode_sel_o),
        .sys_o(sys_regs_o), .act_o(mode_bank_o)
    );
endmodule

// File: rtl/ser_write_if_chk.sv
`timescale 1ns/1ps
module ser_write_if_chk
    import ser_cfg_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      ld_sync,
    input logic                      ctrl_vld,
    input logic                      bank_vld,
    input bank_e                     bank_sel,
    input logic [IDX_W-1:0]          bank_idx,
    input logic                      proto_err,
    input logic [CTRL_N*CDATA_W-1:0] ctrl_regs,
    input logic [SYS_N*WORD_W-1:0]   sys_regs
);
    p_err_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> !proto_err);

    p_err_on_fall_r11: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> (!$past(ld_sync) && $past(ld_sync, 2)));

    p_commit_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl_vld |-> ($past(ld_sync) && !$past(ld_sync, 2)));

    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_regs) |-> $past(ctrl_vld));

    p_bank_idx_r8: assert property (@(posedge clk) disable iff (rst)
        bank_vld |-> (bank_idx < bank_size(bank_sel)));

    p_sys_change_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(sys_regs) |-> $past(bank_vld && bank_sel == BK_SYS));
endmodule

bind ser_write_if ser_write_if_chk u_chk (
    .clk(clk), .rst(rst), .ld_sync(s_cur[1]),
    .ctrl_vld(ctrl_wr.valid), .bank_vld(bank_wr.valid),
    .bank_sel(bank_wr.bank), .bank_idx(bank_wr.idx),
    .proto_err(proto_err_o), .ctrl_regs(ctrl_regs_o), .sys_regs(sys_regs_o)
);

// File: tb/ser_write_if_tb.sv
`timescale 1ns/1ps
module ser_write_if_tb;
    import ser_cfg_pkg::*;

    localparam int HALF = 8;

    logic clk = 1'b0, rst = 1'b1, sck = 1'b0, sl = 1'b1, sd = 1'b0;
    logic [CTRL_N*CDATA_W-1:0] ctrl_regs_o;
    logic                      mode_sel_o, proto_err_o;
    logic [SYS_N*WORD_W-1:0]   sys_regs_o;
    logic [MODE_N*WORD_W-1:0]  mode_bank_o;

    always #2 clk = ~clk;

    ser_write_if u_dut (
        .clk(clk), .rst(rst), .ser_clk_i(sck), .ser_load_n_i(sl), .ser_data_i(sd),
        .ctrl_regs_o(ctrl_regs_o), .mode_sel_o(mode_sel_o), .sys_regs_o(sys_regs_o),
        .mode_bank_o(mode_bank_o), .proto_err_o(proto_err_o)
    );

    typedef struct { string req; int sel; int idx; logic [31:0] exp; } exp_t;
    exp_t q[$];
    int n_chk = 0, n_bad = 0, err_seen = 0;
    bit done = 0;

    function automatic logic [31:0] observe(int sel, int idx);
        case (sel)
            0:       return {8'h00, ctrl_regs_o[idx*CDATA_W +: CDATA_W]};
            1:       return sys_regs_o[idx*WORD_W +: WORD_W];
            2:       return mode_bank_o[idx*WORD_W +: WORD_W];
            3:       return {31'b0, mode_sel_o};
            default: return 32'(err_seen);
        endcase
    endfunction

    function automatic logic [31:0] wv(logic [31:0] base, int k);
        return base ^ (32'(k) * 32'h0001_0001);
    endfunction

    // Monitor: counts error pulses and drains the scoreboard queue.
    initial begin
        forever begin
            exp_t it;
            logic [31:0] got;
            @(negedge clk);
            if (!rst && proto_err_o) err_seen++;
            while (q.size() > 0) begin
                it  = q.pop_front();
                got = observe(it.sel, it.idx);
                n_chk++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d idx=%0d actual=%h expected=%h",
                             it.req, it.sel, it.idx, got, it.exp);
                end
            end
        end
    end

    task automatic expect_item(string req, int sel, int idx, logic [31:0] e);
        exp_t it;
        it.req = req; it.sel = sel; it.idx = idx; it.exp = e;
        q.push_back(it);
    endtask

    task automatic wclk(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_out(logic b);
        sd = b; wclk(HALF); sck = 1'b1; wclk(HALF); sck = 1'b0;
    endtask

    task automatic send_bits(logic [63:0] v, int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic sl_fall();
        sl = 1'b0; wclk(HALF);
    endtask

    task automatic gap_pulse();
        wclk(HALF); sck = 1'b1; wclk(HALF); sck = 1'b0; wclk(HALF);
    endtask

    task automatic sl_rise();
        wclk(2); sl = 1'b1; gap_pulse();
    endtask

    task automatic ctrl_write(logic [7:0] a, logic [23:0] d);
        sl_fall(); send_bits(64'({a, d}), 32); sl_rise();
    endtask

    task automatic burst(logic [7:0] a, logic [23:0] cnt, int nw, logic [31:0] base, int split);
        sl_fall();
        send_bits(64'(a), 8);
        send_bits(64'(cnt), 24);
        for (int k = 0; k < nw; k++) begin
            if (k == split) begin sl_rise(); sl_fall(); end
            send_bits(64'(wv(base, k)), 32);
        end
        sl_rise();
    endtask

    task automatic settle();
        wclk(8);
    endtask

    initial begin
        wclk(5); rst = 1'b0; settle();
        // R1 reset state
        expect_item("R1", 0, 0, 0); expect_item("R1", 0, 7, 0);
        expect_item("R1", 1, 0, 0); expect_item("R1", 1, 16, 0);
        expect_item("R1", 2, 0, 0); expect_item("R1", 3, 0, 0);
        expect_item("R1", 4, 0, 0);
        settle();

        // R3 deferred until strobe rise, R2 lands in slot 3
        sl_fall(); send_bits(64'({8'h21, 24'hABCDEF}), 32); settle();
        expect_item("R3", 0, 3, 0); settle();
        sl_rise(); settle();
        expect_item("R2", 0, 3, 32'hABCDEF);

        // R2 boundary addresses
        ctrl_write(8'h00, 24'h13579B); ctrl_write(8'hD6, 24'hFEDCBA); settle();
        expect_item("R2", 0, 0, 32'h13579B); expect_item("R2", 0, 7, 32'hFEDCBA);

        // R3 short frame discarded
        sl_fall(); send_bits(64'({8'h40, 12'hFFF}), 20); sl_rise(); settle();
        expect_item("R3", 0, 4, 0);

        // R4 surplus bits in one low period
        sl_fall(); send_bits(64'({8'h7F, 24'h123456}), 32);
        send_bits(64'({8'h03, 24'hFFFFFF}), 32); sl_rise(); settle();
        expect_item("R4", 0, 5, 32'h123456); expect_item("R4", 0, 1, 0);

        // R5 unimplemented address
        ctrl_write(8'h05, 24'hC0FFEE); settle();
        expect_item("R5", 0, 0, 32'h13579B); expect_item("R5", 0, 1, 0);
        expect_item("R5", 0, 2, 0);          expect_item("R5", 0, 3, 32'hABCDEF);
        expect_item("R5", 0, 4, 0);          expect_item("R5", 0, 5, 32'h123456);
        expect_item("R5", 0, 6, 0);          expect_item("R5", 0, 7, 32'hFEDCBA);
        expect_item("R5", 1, 0, 0);

        // R3 last clock rise and strobe rise together
        sl_fall(); send_bits(64'({8'hA5, 24'h5A5A5A}) >> 1, 31);
        sd = 1'b0; wclk(HALF); sck = 1'b1; sl = 1'b1; wclk(HALF); sck = 1'b0;
        gap_pulse(); settle();
        expect_item("R3", 0, 6, 32'h5A5A5A);

        // R10 mode bank A, count zero
        burst(8'h15, 24'd0, 8, 32'hA000_0000, -1); settle();
        for (int k = 0; k < MODE_N; k++) expect_item("R10", 2, k, wv(32'hA000_0000, k));
        expect_item("R6", 3, 0, 0);

        // R10 mode bank B, count three; A still shown
        burst(8'h16, 24'd3, 3, 32'hB000_0000, -1); settle();
        expect_item("R6", 2, 0, wv(32'hA000_0000, 0));

        // R6 switch to bank B
        ctrl_write(8'h0A, 24'h000001); settle();
        expect_item("R6", 3, 0, 1);
        expect_item("R6", 2, 0, wv(32'hB000_0000, 0));
        expect_item("R10", 2, 2, wv(32'hB000_0000, 2));
        expect_item("R8", 2, 3, 0);

        // R7 / R9 full system burst split by a strobe high period
        burst(8'h14, 24'd0, SYS_N, 32'h5000_0000, 5); settle();
        expect_item("R7", 1, 0, wv(32'h5000_0000, 0));
        expect_item("R9", 1, 4, wv(32'h5000_0000, 4));
        expect_item("R9", 1, 5, wv(32'h5000_0000, 5));
        expect_item("R7", 1, 16, wv(32'h5000_0000, 16));

        // R8 oversize count clamps, surplus ignored
        burst(8'h14, 24'd20, 19, 32'h7000_0000, -1); settle();
        expect_item("R8", 1, 0, wv(32'h7000_0000, 0));
        expect_item("R8", 1, 16, wv(32'h7000_0000, 16));
        ctrl_write(8'h40, 24'h0000AA); settle();
        expect_item("R4", 0, 4, 32'h0000AA);

        // R8 short count leaves later entries
        burst(8'h14, 24'd2, 2, 32'h9000_0000, -1); settle();
        expect_item("R8", 1, 1, wv(32'h9000_0000, 1));
        expect_item("R8", 1, 2, wv(32'h7000_0000, 2));
        expect_item("R11", 4, 0, 0);
        settle();

        // R11 too-short high period
        sl_fall(); send_bits(64'({8'h03, 24'h0F0F0F}), 32);
        wclk(2); sl = 1'b1; wclk(4); sl = 1'b0; wclk(HALF);
        send_bits(64'({8'h00, 24'h2468AC}), 32); sl_rise(); settle();
        expect_item("R11", 4, 0, 1);
        expect_item("R11", 0, 1, 32'h0F0F0F);
        expect_item("R11", 0, 0, 32'h2468AC);
        ctrl_write(8'hA5, 24'h000777); settle();
        expect_item("R11", 4, 0, 1);
        expect_item("R2", 0, 6, 32'h000777);

        wclk(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule